// File: doc/BRIEF.md
# Register Rename Map with Free List

This block translates the logical register numbers of one decoded instruction per cycle into physical register tags. A table with one physical tag per logical register supplies the tags of the two sources, and a first-in first-out list of unused physical registers supplies a fresh tag for the destination. Both source lookups use the table as it stands before this instruction's own destination is allocated. A source that names the same logical register as the destination therefore still sees the older producer. Giving every write a fresh physical register removes write-after-read and write-after-write conflicts.

The source tags, the new destination tag and the destination's previous tag are all combinational outputs of the current request. The previous tag is output so that a later commit stage can return it. Returned tags come back through a release port and join the tail of the free list. The table entry and the free-list head change on the clock edge that accepts the request. If a destination is needed while the list is empty, the block raises stall and changes nothing. Logical register 0 is wired to physical register 0.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i for every i, and the free list holds physical registers LOG_REGS to PHYS_REGS-1 (32 to 63 by default) in ascending order.
- R2: `src_a_tag` and `src_b_tag` show the current table entries for `src_a` and `src_b` in the same cycle, whether or not `dec_valid` is set.
- R3: A request allocates a register when `dec_valid` and `dst_we` are 1 and `dst` is not 0, and the list is not empty. Such a request gets the free-list head on `dst_tag` in the same cycle. From the next cycle on, the table maps `dst` to that tag.
- R4: A source equal to the destination of the same request reads the mapping that held before the allocation.
- R5: The list hands out registers in first-in first-out order. Registers that are released are appended behind the ones already waiting.
- R6: If a request needs a register while the list is empty, `stall` is 1 and `dst_tag` is 0. The table and the list stay unchanged.
- R7: Logical register 0 always reads physical 0. A request whose destination is 0 allocates nothing and leaves `dst_tag` at 0.
- R8: On an allocating request, `prev_tag` carries the tag that `dst` was mapped to before this request. On any other request it is 0.
- R9: A release with `rel_valid` set and `rel_tag` equal to 0 is ignored, so physical 0 never enters the list.
- R10: A request with `dec_valid` at 0 or `dst_we` at 0 allocates nothing. `dst_tag` and `prev_tag` read 0, and the list head is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| src_a | input | LW | First logical source |
| src_b | input | LW | Second logical source |
| dst | input | LW | Logical destination |
| dst_we | input | 1 | Instruction writes its destination |
| rel_valid | input | 1 | Return a physical register to the list |
| rel_tag | input | PW | Physical register being returned |
| src_a_tag | output | PW | Physical tag of the first source |
| src_b_tag | output | PW | Physical tag of the second source |
| dst_tag | output | PW | Newly allocated physical tag, or 0 |
| prev_tag | output | PW | Previous physical tag of the destination, or 0 |
| stall | output | 1 | Request needs a register but the list is empty |

## Verification
The four tags and `stall` depend only on the current inputs and the stored state. The bench applies each request after a falling edge and samples a short settle time later, well before the next rising edge. The table write, the list pop and the release push take effect on that rising edge. Their results are therefore checked one request later, through the source lookups and the next allocation order. The bench's own table and list model is updated only after that edge, so every expected value reflects the state the design holds at the moment of sampling.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
   localparam int RNM_LOG_REGS_DEF  = 32;
   localparam int RNM_PHYS_REGS_DEF = 64;

   function automatic bit rnm_is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

   // Reset content of free-list slot k: the first physical register not used by the map, plus k.
   function automatic int rnm_seed_tag(input int k, input int log_regs);
      return log_regs + k;
   endfunction
endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
   parameter int LOG_REGS  = 32,
   parameter int PHYS_REGS = 64,
   localparam int LW = $clog2(LOG_REGS),
   localparam int PW = $clog2(PHYS_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_a_idx,
   input  logic [LW-1:0] rd_b_idx,
   input  logic [LW-1:0] rd_d_idx,
   output logic [PW-1:0] rd_a_tag,
   output logic [PW-1:0] rd_b_tag,
   output logic [PW-1:0] rd_d_tag,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_idx,
   input  logic [PW-1:0] wr_tag
);
   logic [PW-1:0] ent [LOG_REGS];

   for (genvar i = 0; i < LOG_REGS; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign ent[i] = '0;
      end else begin : g_reg
         logic [PW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= PW'(i);
            else if (wr_en && (wr_idx == LW'(i)))
               q <= wr_tag;
         end
         assign ent[i] = q;
      end
   end

   // Reads see the table before this cycle's write.
   assign rd_a_tag = ent[rd_a_idx];
   assign rd_b_tag = ent[rd_b_idx];
   assign rd_d_tag = ent[rd_d_idx];

   // R3
   written_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent[$past(wr_idx)] == $past(wr_tag));
   // R7
   zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx != '0) && (wr_tag != '0));
endmodule

// File: rtl/rnm_free_fifo.sv
module rnm_free_fifo #(
   parameter int LOG_REGS  = 32,
   parameter int PHYS_REGS = 64,
   localparam int PW    = $clog2(PHYS_REGS),
   localparam int DEPTH = PHYS_REGS,
   localparam int SEEDS = PHYS_REGS - LOG_REGS,
   localparam int CW    = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          push,
   input  logic [PW-1:0] push_tag,
   output logic [PW-1:0] head_tag,
   output logic          empty
);
   logic [PW-1:0] slot [DEPTH];
   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] wr_ptr;
   logic [CW-1:0] count;

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      logic [PW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            if (k < SEEDS)
               q <= PW'(rnm_pkg::rnm_seed_tag(k, LOG_REGS));
            else
               q <= '0;
         end else if (push && (wr_ptr == PW'(k))) begin
            q <= push_tag;
         end
      end
      assign slot[k] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= PW'(SEEDS);
         count  <= CW'(SEEDS);
      end else begin
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         if (push) wr_ptr <= wr_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_tag = slot[rd_ptr];
   assign empty    = (count == '0);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> count < CW'(DEPTH));
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R5
   pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> count == $past(count) - 1'b1);
   // R9
   zero_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> push_tag != '0);
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
   parameter int LOG_REGS  = rnm_pkg::RNM_LOG_REGS_DEF,
   parameter int PHYS_REGS = rnm_pkg::RNM_PHYS_REGS_DEF,
   localparam int LW = $clog2(LOG_REGS),
   localparam int PW = $clog2(PHYS_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_valid,
   input  logic [LW-1:0] src_a,
   input  logic [LW-1:0] src_b,
   input  logic [LW-1:0] dst,
   input  logic          dst_we,
   input  logic          rel_valid,
   input  logic [PW-1:0] rel_tag,
   output logic [PW-1:0] src_a_tag,
   output logic [PW-1:0] src_b_tag,
   output logic [PW-1:0] dst_tag,
   output logic [PW-1:0] prev_tag,
   output logic          stall
);
   initial begin
      assert (rnm_pkg::rnm_is_pow2(LOG_REGS)) else $error("LOG_REGS must be a power of two");
      assert (rnm_pkg::rnm_is_pow2(PHYS_REGS)) else $error("PHYS_REGS must be a power of two");
      assert (PHYS_REGS > LOG_REGS) else $error("PHYS_REGS must exceed LOG_REGS");
   end

   logic          alloc_req;
   logic          fire;
   logic          fl_empty;
   logic          fl_push;
   logic [PW-1:0] fl_head;
   logic [PW-1:0] old_map;

   assign alloc_req = dec_valid && dst_we && (dst != '0);
   assign fire      = alloc_req && !fl_empty;
   assign fl_push   = rel_valid && (rel_tag != '0);

   rnm_map_table #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) i_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (src_a),
      .rd_b_idx (src_b),
      .rd_d_idx (dst),
      .rd_a_tag (src_a_tag),
      .rd_b_tag (src_b_tag),
      .rd_d_tag (old_map),
      .wr_en    (fire),
      .wr_idx   (dst),
      .wr_tag   (fl_head)
   );

   rnm_free_fifo #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) i_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (fire),
      .push     (fl_push),
      .push_tag (rel_tag),
      .head_tag (fl_head),
      .empty    (fl_empty)
   );

   assign dst_tag  = fire ? fl_head : '0;
   assign prev_tag = fire ? old_map : '0;
   assign stall    = alloc_req && fl_empty;

   // R6
   stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (dst_tag == '0) && (prev_tag == '0));
   // R10
   idle_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_valid || !dst_we) |-> (dst_tag == '0) && !stall);
   // R4
   self_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_tag != '0 && src_a == dst) |-> src_a_tag == prev_tag);
endmodule

// File: tb/test_rename_map_unit.sv
module test_rename_map_unit;
   localparam int NL = 32;
   localparam int NP = 64;
   localparam int LW = $clog2(NL);
   localparam int PW = $clog2(NP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dec_valid = 1'b0;
   logic [LW-1:0] src_a = '0, src_b = '0, dst = '0;
   logic          dst_we = 1'b0;
   logic          rel_valid = 1'b0;
   logic [PW-1:0] rel_tag = '0;
   logic [PW-1:0] src_a_tag, src_b_tag, dst_tag, prev_tag;
   logic          stall;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Bench model
   int m_map [NL];
   int m_fl  [NP];
   int m_hd, m_tl, m_cnt;
   int pend [NP];
   int p_hd = 0, p_tl = 0, p_cnt = 0;
   int last_alloc;

   always #10 clk = ~clk;

   rename_map_unit #(.LOG_REGS(NL), .PHYS_REGS(NP)) i_rename_map_unit (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .src_a(src_a), .src_b(src_b),
      .dst(dst), .dst_we(dst_we), .rel_valid(rel_valid), .rel_tag(rel_tag),
      .src_a_tag(src_a_tag), .src_b_tag(src_b_tag), .dst_tag(dst_tag),
      .prev_tag(prev_tag), .stall(stall)
   );

   task automatic chk(input string rq, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
      end
   endtask

   task automatic step(input string rq, input bit va, input int sa, input int sb,
                       input int d, input bit we, input bit rv, input int rt);
      bit need, e_stall, take;
      int e_dst, e_prev;
      @(negedge clk);
      dec_valid = va; src_a = LW'(sa); src_b = LW'(sb); dst = LW'(d);
      dst_we = we; rel_valid = rv; rel_tag = PW'(rt);
      #2;
      need    = va && we && (d != 0);
      e_stall = need && (m_cnt == 0);
      take    = need && (m_cnt != 0);
      e_dst   = take ? m_fl[m_hd] : 0;
      e_prev  = take ? m_map[d] : 0;
      chk(rq, "src_a_tag", int'(src_a_tag), m_map[sa]);
      chk(rq, "src_b_tag", int'(src_b_tag), m_map[sb]);
      chk(rq, "dst_tag",   int'(dst_tag),   e_dst);
      chk(rq, "prev_tag",  int'(prev_tag),  e_prev);
      chk(rq, "stall",     int'(stall),     int'(e_stall));
      @(posedge clk);
      last_alloc = 0;
      if (take) begin
         last_alloc = e_dst;
         pend[p_tl] = e_prev; p_tl = (p_tl + 1) % NP; p_cnt++;
         m_map[d] = e_dst; m_hd = (m_hd + 1) % NP; m_cnt--;
      end
      if (rv && rt != 0) begin
         m_fl[m_tl] = rt; m_tl = (m_tl + 1) % NP; m_cnt++;
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int lfsr = 32'h1ACE_B00C;
      for (int i = 0; i < NL; i++) m_map[i] = i;
      for (int k = 0; k < NP; k++) m_fl[k] = (k < NP - NL) ? NL + k : 0;
      m_hd = 0; m_tl = NP - NL; m_cnt = NP - NL;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "stall after reset", int'(stall), 0);

      // R1 / R2: identity map after reset, both read ports
      for (int i = 0; i < NL; i++) step("R1", 1'b0, i, NL - 1 - i, 0, 1'b0, 1'b0, 0);
      // R4: source equals destination, expects 3 -> 32 with old tag 3 on the sources
      step("R4", 1'b1, 3, 3, 3, 1'b1, 1'b0, 0);
      // R3: new mapping visible next cycle, next head is 33
      step("R3", 1'b1, 3, 0, 5, 1'b1, 1'b0, 0);
      chk("R3", "r3 mapped to 32", m_map[3], 32);
      // R7: destination 0 allocates nothing
      step("R7", 1'b1, 0, 5, 0, 1'b1, 1'b0, 0);
      // R10: not valid / not writing
      step("R10", 1'b0, 6, 7, 6, 1'b1, 1'b0, 0);
      step("R10", 1'b1, 6, 7, 6, 1'b0, 1'b0, 0);
      // R5 / R8: drain the list in order
      for (int j = 0; m_cnt > 0; j++) begin
         step("R5", 1'b1, (j % 31) + 1, 0, (j % 31) + 1, 1'b1, 1'b0, 0);
         chk("R5", "allocation order", last_alloc, NL + 2 + j);
      end
      // R6: empty list stalls, table unchanged afterwards
      step("R6", 1'b1, 9, 9, 9, 1'b1, 1'b0, 0);
      step("R6", 1'b0, 9, 1, 0, 1'b0, 1'b0, 0);
      // R9: releasing 0 is ignored, releasing 40 is queued
      step("R9", 1'b0, 0, 0, 0, 1'b0, 1'b1, 0);
      step("R9", 1'b1, 2, 4, 7, 1'b1, 1'b0, 0);
      step("R9", 1'b0, 0, 0, 0, 1'b0, 1'b1, 40);
      step("R9", 1'b1, 7, 0, 7, 1'b1, 1'b0, 0);
      chk("R9", "released tag allocated", last_alloc, 40);
      step("R9", 1'b1, 8, 0, 8, 1'b1, 1'b0, 0);
      p_hd = 0; p_tl = 0; p_cnt = 0;
      for (int k = 0; k < NP; k++) pend[k] = 0;
      // rebuild pending from tags not mapped: unmapped non-zero tags are free-able
      begin
         bit used [NP];
         for (int k = 0; k < NP; k++) used[k] = 1'b0;
         for (int i = 0; i < NL; i++) used[m_map[i]] = 1'b1;
         for (int k = 1; k < NP; k++)
            if (!used[k] && k != 40) begin pend[p_tl] = k; p_tl++; p_cnt++; end
      end
      // R5 / R2 / R8: mixed traffic with releases appended at the tail
      for (int s = 0; s < 800; s++) begin
         bit rv;
         int rt;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         rv = (p_cnt > 0) && lfsr[3];
         rt = 0;
         if (rv) begin rt = pend[p_hd]; p_hd = (p_hd + 1) % NP; p_cnt--; end
         else if (lfsr[9] && lfsr[10]) rv = 1'b1;  // R9 zero release mixed in
         step("R5", lfsr[4] | lfsr[5], lfsr[10:6], lfsr[15:11], lfsr[20:16],
              lfsr[21] | lfsr[22], rv, rt);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule